// File: doc/BRIEF.md
# Masked Ternary Match Table

This block is a small ternary match table for a packet parser. Every entry holds an 84-bit key pattern, an 84-bit care mask and an invalid flag. A lookup presents a search key. One cycle later the block reports whether any valid entry matched and which entry matched. When several entries match, the lowest-numbered entry wins. Each entry also has a saturating hit counter. Software selects a counter through a select register and reads it back through a count register.

Software reaches the table through a simple word-addressed register port. It writes an entry number into the index register, then reads or writes that entry's six 32-bit words in place. In words 0 to 4, the low half of each word carries 16 key-pattern bits and the high half carries the matching 16 mask bits. Word 5 carries the 4-bit lookup stage and the invalid flag. A global enable bit forces every lookup to miss while it is cleared. A single command starts a sweep that invalidates every entry, one entry per cycle, and keeps a busy output high while the sweep runs.

Top module: `tcam_match_table`

## Requirements
- R1: After reset, every entry is invalid and the enable bit is 0. Every lookup misses, busy is low, every hit counter is 0, and word 5 of entry 0 reads 32'h8000_0000.
- R2: The registers sit at these addresses: 0 entry index, 1 to 6 entry words 0 to 5, 7 control, 8 counter select, 9 counter value, 10 command. Word w (0 to 4) carries key-pattern bits [16w+15:16w] in bits [15:0] and the mask for those bits in bits [31:16]. Every written word reads back unchanged. The search key is laid out as {stage[3:0], port[7:0], flags[7:0], header[63:0]}, so stage occupies key bits [83:80].
- R3: In word 5, bits [3:0] hold the stage pattern and bit 31 holds the invalid flag. Any write to word 5 sets the stage mask to all ones, whatever the written value. Word 5 reads back as {invalid, 11'b0, stage mask, 12'b0, stage}.
- R4: A valid entry matches when ((key XOR pattern) AND mask) is zero. A mask bit of 0 makes that key bit don't-care. An entry whose invalid flag is 1 never matches.
- R5: Bit 0 of the control register enables the table. While it is 0, every lookup reports a miss.
- R6: When several entries match, the lowest index is reported.
- R7: lk_done pulses in the cycle after lk_req and carries lk_hit and lk_idx. lk_idx is 0 on a miss, and lk_done is low when no request was made.
- R8: The counter-value register returns the hit count of the entry named by the counter-select register. The count rises by one for each lookup that entry wins.
- R9: A hit counter stops at 16'hFFFF and does not wrap.
- R10: A write to any word of an entry clears that entry's hit counter.
- R11: Writing 1 to bit 0 of the command register raises busy on the next cycle. Busy stays high for exactly DEPTH cycles while the entries are invalidated one per cycle. Afterwards every entry misses and reads its invalid flag as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| lk_req | input | 1 | Lookup request |
| lk_key | input | 84 | Search key {stage, port, flags, header} |
| lk_done | output | 1 | Lookup result strobe |
| lk_hit | output | 1 | Some valid entry matched |
| lk_idx | output | $clog2(DEPTH) | Winning entry index |
| busy | output | 1 | Invalidate-all sweep in progress |

## Verification
The bench programs two entries that match the same key, one with a narrow mask and one with a wide mask. A broken priority encoder would report the higher index.

Two entries in particular guard the stage mask and the invalid flag. One entry has its stage mask written as zero; if the mask were not forced to all ones, it would match a key carrying a different stage. Another entry has an all-don't-care mask but is written invalid; if the invalid flag were ignored, it would still hit.

The counter tests cover three failures. A counter that is not reset on rewrite keeps its old count. A counter held in a stream of more than 65,535 hits must stop at 16'hFFFF; one that wraps reads a small value. The sweep's busy length is counted exactly, so an off-by-one sweep that leaves the last entry valid, or a busy flag that drops one cycle late, is caught.

// File: rtl/tcam_match_table.sv
module tcam_match_table #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [3:0]               reg_addr,
  input  logic                     reg_wr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic                     lk_req,
  input  logic [83:0]              lk_key,
  output logic                     lk_done,
  output logic                     lk_hit,
  output logic [$clog2(DEPTH)-1:0] lk_idx,
  output logic                     busy
);
  localparam int IDXW = $clog2(DEPTH);
  localparam int KW   = 84;
  localparam int STG  = 80;
  localparam logic [3:0] A_IDX  = 4'd0;
  localparam logic [3:0] A_W0   = 4'd1;
  localparam logic [3:0] A_W5   = 4'd6;
  localparam logic [3:0] A_CTRL = 4'd7;
  localparam logic [3:0] A_HSEL = 4'd8;
  localparam logic [3:0] A_HCNT = 4'd9;
  localparam logic [3:0] A_CMD  = 4'd10;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [KW-1:0]    pat_q  [DEPTH];
  logic [KW-1:0]    msk_q  [DEPTH];
  logic [CNT_W-1:0] cnt_q  [DEPTH];
  logic [DEPTH-1:0] inv_q;
  logic [IDXW-1:0]  idx_q, hsel_q, swp_q, win;
  logic             en_q, hit_any;
  logic [DEPTH-1:0] match_v, clr_v;

  wire       word_wr = reg_wr && (reg_addr >= A_W0) && (reg_addr <= A_W5);
  wire [2:0] wsel    = 3'(reg_addr - A_W0);
  wire       cmd_go  = reg_wr && (reg_addr == A_CMD) && reg_wdata[0];

  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      match_v[e] = en_q && !inv_q[e] && (((lk_key ^ pat_q[e]) & msk_q[e]) == '0);
      clr_v[e]   = word_wr && (idx_q == IDXW'(e));
    end
  end

  always_comb begin
    win     = '0;
    hit_any = 1'b0;
    for (int e = DEPTH - 1; e >= 0; e--) begin
      if (match_v[e]) begin
        win     = IDXW'(e);
        hit_any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      hsel_q <= '0;
      en_q   <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == A_IDX)  idx_q  <= reg_wdata[IDXW-1:0];
      if (reg_addr == A_HSEL) hsel_q <= reg_wdata[IDXW-1:0];
      if (reg_addr == A_CTRL) en_q   <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        pat_q[e] <= '0;
        msk_q[e] <= '0;
      end
    end else if (word_wr) begin
      if (wsel < 3'd5) begin
        pat_q[idx_q][int'(wsel)*16 +: 16] <= reg_wdata[15:0];
        msk_q[idx_q][int'(wsel)*16 +: 16] <= reg_wdata[31:16];
      end else begin
        pat_q[idx_q][STG +: 4] <= reg_wdata[3:0];
        msk_q[idx_q][STG +: 4] <= 4'hF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_q <= '1;
      busy  <= 1'b0;
      swp_q <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (busy && swp_q == IDXW'(e))
          inv_q[e] <= 1'b1;
        else if (clr_v[e] && wsel == 3'd5)
          inv_q[e] <= reg_wdata[31];
      end
      if (busy) begin
        if (swp_q == IDXW'(DEPTH - 1)) busy <= 1'b0;
        else swp_q <= swp_q + 1'b1;
      end else if (cmd_go) begin
        busy  <= 1'b1;
        swp_q <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) cnt_q[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (clr_v[e])
          cnt_q[e] <= '0;
        else if (lk_req && hit_any && win == IDXW'(e) && cnt_q[e] != CNT_MAX)
          cnt_q[e] <= cnt_q[e] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_done <= 1'b0;
      lk_hit  <= 1'b0;
      lk_idx  <= '0;
    end else begin
      lk_done <= lk_req;
      lk_hit  <= lk_req && hit_any;
      lk_idx  <= lk_req ? win : '0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_IDX)
      reg_rdata = 32'(idx_q);
    else if (reg_addr >= A_W0 && reg_addr < A_W5)
      reg_rdata = {msk_q[idx_q][int'(wsel)*16 +: 16], pat_q[idx_q][int'(wsel)*16 +: 16]};
    else if (reg_addr == A_W5)
      reg_rdata = {inv_q[idx_q], 11'b0, msk_q[idx_q][STG +: 4], 12'b0, pat_q[idx_q][STG +: 4]};
    else if (reg_addr == A_CTRL)
      reg_rdata = {31'b0, en_q};
    else if (reg_addr == A_HSEL)
      reg_rdata = 32'(hsel_q);
    else if (reg_addr == A_HCNT)
      reg_rdata = 32'(cnt_q[hsel_q]);
    else if (reg_addr == A_CMD)
      reg_rdata = {31'b0, busy};
  end

  logic [DEPTH-1:0] inv_seen;
  always_ff @(posedge clk) inv_seen <= inv_q;
  wire [CNT_W-1:0] sel_cnt = cnt_q[hsel_q];

  a_r7_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_done);
  a_r5_no_hit_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done && lk_hit |-> $past(en_q));
  a_r4_hit_entry_valid: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done && lk_hit |-> !inv_seen[lk_idx]);
  a_r11_busy_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_go));
  a_r9_count_holds_max: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_cnt) == CNT_MAX && $stable(hsel_q) && !$past(clr_v[hsel_q]) |-> sel_cnt == CNT_MAX);
endmodule

// File: tb/tcam_match_table_tb_top.sv
module tcam_match_table_tb_top;
  localparam int DEPTH = 16;
  localparam int IDXW  = $clog2(DEPTH);
  localparam int NV    = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic lk_req = 1'b0;
  logic [83:0] lk_key = '0;
  logic lk_done, lk_hit, busy;
  logic [IDXW-1:0] lk_idx;

  always #10 clk = ~clk;

  tcam_match_table #(.DEPTH(DEPTH), .CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req),
    .lk_key(lk_key), .lk_done(lk_done), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .busy(busy));

  // {key[83:0], hit, idx[3:0]} ; key = {stage, port, flags, header}
  localparam logic [88:0] VEC [NV] = '{
    {4'h1, 8'h00, 8'h00, 64'h0000_0000_0000_0800, 1'b1, 4'd0},
    {4'h1, 8'h00, 8'h00, 64'h0000_0000_0000_0806, 1'b1, 4'd2},
    {4'h2, 8'h05, 8'hC1, 64'h0,                   1'b1, 4'd1},
    {4'h2, 8'h05, 8'h41, 64'h0,                   1'b0, 4'd0},
    {4'h2, 8'h06, 8'h80, 64'h0,                   1'b0, 4'd0},
    {4'h4, 8'hAA, 8'h55, 64'h1234,                1'b1, 4'd4},
    {4'h5, 8'hAA, 8'h55, 64'h1234,                1'b0, 4'd0},
    {4'h6, 8'h00, 8'h00, 64'h0,                   1'b0, 4'd0},
    {4'h1, 8'h33, 8'h44, 64'hFFFF_0000_0000_0800, 1'b1, 4'd0}
  };

  int total = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic put_entry(int idx, logic [3:0] stg, logic [7:0] port, logic [7:0] pm,
                           logic [7:0] fl, logic [7:0] fm, logic [63:0] hdr,
                           logic [63:0] hm, logic inv);
    wr(4'd0, 32'(idx));
    for (int w = 0; w < 4; w++) wr(4'(1 + w), {hm[16*w +: 16], hdr[16*w +: 16]});
    wr(4'd5, {pm, fm, port, fl});
    wr(4'd6, {inv, 11'b0, 4'h0, 12'b0, stg});
  endtask

  task automatic look(logic [83:0] k, output logic d, output logic h, output logic [IDXW-1:0] i);
    @(negedge clk);
    lk_key = k; lk_req = 1'b1;
    @(negedge clk);
    lk_req = 1'b0;
    d = lk_done; h = lk_hit; i = lk_idx;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; total++;
      $display("FAIL watchdog R7 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic d, h;
    logic [IDXW-1:0] i;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd7, r);      chk("R1 enable off", 64'(r), 64'h0);
    rd(4'd6, r);      chk("R1 entry0 word5", 64'(r), 64'h8000_0000);
    rd(4'd9, r);      chk("R1 counter zero", 64'(r), 64'h0);
    chk("R1 busy low", 64'(busy), 64'h0);
    wr(4'd7, 32'h1);
    look(VEC[0][88:5], d, h, i);
    chk("R1 no hit after reset", 64'(h), 64'h0);
    wr(4'd7, 32'h0);

    put_entry(0, 4'h1, 8'h00, 8'h00, 8'h00, 8'h00, 64'h0800, 64'hFFFF, 1'b0);
    put_entry(1, 4'h2, 8'h05, 8'hFF, 8'h80, 8'h80, 64'h0, 64'h0, 1'b0);
    put_entry(2, 4'h1, 8'h00, 8'h00, 8'h00, 8'h00, 64'h0, 64'h0, 1'b0);
    put_entry(3, 4'h1, 8'h00, 8'h00, 8'h00, 8'h00, 64'h0800, 64'hFFFF, 1'b0);
    put_entry(4, 4'h4, 8'h00, 8'h00, 8'h00, 8'h00, 64'h0, 64'h0, 1'b0);
    put_entry(5, 4'h6, 8'h00, 8'h00, 8'h00, 8'h00, 64'h0, 64'h0, 1'b1);

    // R2 / R3 readback
    wr(4'd0, 32'd1);
    rd(4'd5, r);      chk("R2 word4 readback", 64'(r), 64'hFF80_0580);
    wr(4'd0, 32'd0);
    rd(4'd1, r);      chk("R2 word0 readback", 64'(r), 64'hFFFF_0800);
    wr(4'd0, 32'd4);
    rd(4'd6, r);      chk("R3 stage mask forced", 64'(r), 64'h000F_0004);
    wr(4'd0, 32'd5);
    rd(4'd6, r);      chk("R3 invalid flag readback", 64'(r), 64'h800F_0006);

    // R5 disabled
    look(VEC[0][88:5], d, h, i);
    chk("R5 miss when disabled", 64'(h), 64'h0);
    wr(4'd7, 32'h1);

    // R4 R6 R7 vector walk
    for (int v = 0; v < NV; v++) begin
      look(VEC[v][88:5], d, h, i);
      chk("R7 done strobe", 64'(d), 64'h1);
      chk("R4 R6 hit", 64'(h), 64'(VEC[v][4]));
      chk("R6 R7 index", 64'(i), 64'(VEC[v][3:0]));
    end
    @(negedge clk);
    chk("R7 no done without request", 64'(lk_done), 64'h0);

    // R8 counters
    wr(4'd8, 32'd0);
    rd(4'd9, r);      chk("R8 count entry0", 64'(r), 64'd2);
    wr(4'd8, 32'd3);
    rd(4'd9, r);      chk("R8 count shadowed entry3", 64'(r), 64'd0);
    wr(4'd8, 32'd1);
    rd(4'd9, r);      chk("R8 count entry1", 64'(r), 64'd1);

    // R10 clear on rewrite
    wr(4'd8, 32'd0);
    wr(4'd0, 32'd0);
    wr(4'd1, 32'hFFFF_0800);
    rd(4'd9, r);      chk("R10 cleared on rewrite", 64'(r), 64'd0);

    // R9 saturation on entry 2
    wr(4'd8, 32'd2);
    @(negedge clk);
    lk_key = VEC[1][88:5]; lk_req = 1'b1;
    repeat (65540) @(negedge clk);
    lk_req = 1'b0;
    rd(4'd9, r);      chk("R9 saturated", 64'(r), 64'hFFFF);
    look(VEC[1][88:5], d, h, i);
    rd(4'd9, r);      chk("R9 stays saturated", 64'(r), 64'hFFFF);

    // R5 disable again
    wr(4'd7, 32'h0);
    look(VEC[5][88:5], d, h, i);
    chk("R5 miss after disable", 64'(h), 64'h0);
    wr(4'd7, 32'h1);

    // R11 invalidate all
    wr(4'd10, 32'h1);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk("R11 busy length", 64'(n), 64'(DEPTH));
    look(VEC[5][88:5], d, h, i);
    chk("R11 miss after sweep", 64'(h), 64'h0);
    look(VEC[0][88:5], d, h, i);
    chk("R11 entry0 miss after sweep", 64'(h), 64'h0);
    wr(4'd0, 32'd4);
    rd(4'd6, r);      chk("R11 invalid flag set", 64'(r), 64'h800F_0004);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule